// File: doc/BRIEF.md
# Lookahead Adder-Subtractor with Carry and Overflow Flags

This block adds or subtracts two small two's-complement or unsigned operands. It selects the operation with a single mode input. It does not use a ripple chain. Each bit position forms a generate term and a propagate term from the first operand and the (possibly inverted) second operand. Every carry, including the end carry, is then produced at once as a flat sum of products over those terms and the carry-in. In subtract mode the second operand is inverted bit by bit and the carry-in is forced high, so the same adder yields A plus the two's complement of B.

Two flags come with the result. The carry flag is the end carry out of the top position: it marks unsigned overflow on addition, and on subtraction it is high when no borrow occurs. The overflow flag is the XOR of the carry into the sign position and the carry out of it, and it marks signed overflow. The arithmetic core is purely combinational. Its result and flags are captured in one output register, so each operation shows up one clock after its operands are sampled.

Top module: `lasub_addsub`

## Requirements
- R1: With `sub_i`=0, `sum_o` equals (`a_i` + `b_i`) modulo 2^WIDTH.
- R2: With `sub_i`=1, `sum_o` equals (`a_i` - `b_i`) modulo 2^WIDTH.
- R3: With `sub_i`=0, `carry_o` is 1 exactly when the unsigned sum `a_i` + `b_i` is 2^WIDTH or more.
- R4: With `sub_i`=1, `carry_o` is 1 exactly when `a_i` >= `b_i` as unsigned numbers (no borrow), and 0 when a borrow occurs.
- R5: With `sub_i`=0, `ovf_o` is 1 exactly when the two's-complement sum of `a_i` and `b_i` lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1].
- R6: With `sub_i`=1, `ovf_o` is 1 exactly when the two's-complement difference `a_i` - `b_i` lies outside that range.
- R7: While `rst_n` is 0, `sum_o`, `carry_o` and `ovf_o` are all 0, whatever the operand inputs hold.
- R8: Outputs reflect the operands and mode sampled at the previous rising edge of `clk`, exactly one cycle of latency, with WIDTH=4 by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a_i | input | WIDTH | First operand (minuend on subtraction) |
| b_i | input | WIDTH | Second operand (subtrahend on subtraction) |
| sub_i | input | 1 | Mode: 0 adds, 1 subtracts |
| sum_o | output | WIDTH | Registered result |
| carry_o | output | 1 | Registered end carry (unsigned overflow / not-borrow) |
| ovf_o | output | 1 | Registered signed overflow |

## Verification
The assertions assume that `a_i`, `b_i` and `sub_i` carry known values at every rising edge after reset is released. They also assume that a value seen one cycle earlier through `$past` is the one the output register captured. The bench drives all inputs only at falling edges and never leaves them undefined. It steps through every operand and mode pair and then applies seeded random vectors, so each edge samples stable, fully defined operands.

// File: rtl/lasub_pkg.sv
package lasub_pkg;

    // Default operand width of one lookahead group.
    parameter int unsigned LASUB_WIDTH = 4;

    // Operation select carried on the mode input.
    typedef enum logic {
        MODE_ADD = 1'b0,
        MODE_SUB = 1'b1
    } lasub_mode_e;

endpackage

// File: rtl/lasub_operand.sv
// Per-bit operand conditioning: conditional inversion of the second
// operand, then generate and propagate terms.
module lasub_operand #(
    parameter int unsigned WIDTH = lasub_pkg::LASUB_WIDTH
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] gen_o,
    output logic [WIDTH-1:0] prop_o,
    output logic             cin_o
);
    import lasub_pkg::*;

    logic [WIDTH-1:0] b_eff;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign b_eff[i]  = b_i[i] ^ sub_i;
        assign gen_o[i]  = a_i[i] & b_eff[i];
        assign prop_o[i] = a_i[i] ^ b_eff[i];
    end

    assign cin_o = (lasub_mode_e'(sub_i) == MODE_SUB);

endmodule

// File: rtl/lasub_carry_gen.sv
// Flattened lookahead: each carry is a two-level OR of AND terms over
// generate, propagate and carry-in, with no dependence on lower carries.
module lasub_carry_gen #(
    parameter int unsigned WIDTH = lasub_pkg::LASUB_WIDTH
) (
    input  logic [WIDTH-1:0] gen_i,
    input  logic [WIDTH-1:0] prop_i,
    input  logic             cin_i,
    output logic [WIDTH:0]   carry_o
);
    assign carry_o[0] = cin_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_carry
        logic sop;
        logic term;
        always_comb begin
            // Carry-in term: cin AND every propagate from bit 0 to bit i.
            term = cin_i;
            for (int k = 0; k <= i; k++) begin
                term = term & prop_i[k];
            end
            sop = term;
            // One product per generating position j at or below i.
            for (int j = 0; j <= i; j++) begin
                term = gen_i[j];
                for (int k = j + 1; k <= i; k++) begin
                    term = term & prop_i[k];
                end
                sop = sop | term;
            end
        end
        assign carry_o[i+1] = sop;
    end

endmodule

// File: rtl/lasub_addsub.sv
// Lookahead adder-subtractor with end-carry and signed-overflow flags,
// result captured in one output register.
module lasub_addsub #(
    parameter int unsigned WIDTH = lasub_pkg::LASUB_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             ovf_o
);
    localparam int unsigned MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] sum;
        logic             carry;
        logic             ovf;
    } result_t;

    logic [WIDTH-1:0] gen;
    logic [WIDTH-1:0] prop;
    logic             cin;
    logic [WIDTH:0]   carry;

    result_t res_d;
    result_t res_q;

    lasub_operand #(.WIDTH(WIDTH)) u_operand (
        .a_i    (a_i),
        .b_i    (b_i),
        .sub_i  (sub_i),
        .gen_o  (gen),
        .prop_o (prop),
        .cin_o  (cin)
    );

    lasub_carry_gen #(.WIDTH(WIDTH)) u_carry_gen (
        .gen_i   (gen),
        .prop_i  (prop),
        .cin_i   (cin),
        .carry_o (carry)
    );

    always_comb begin
        res_d       = '0;
        res_d.sum   = prop ^ carry[WIDTH-1:0];
        res_d.carry = carry[WIDTH];
        res_d.ovf   = carry[WIDTH] ^ carry[MSB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign sum_o   = res_q.sum;
    assign carry_o = res_q.carry;
    assign ovf_o   = res_q.ovf;

endmodule

// File: rtl/lasub_checker.sv
// Temporal checks on the registered adder-subtractor ports.
module lasub_checker #(
    parameter int unsigned WIDTH = lasub_pkg::LASUB_WIDTH
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             sub_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             carry_o,
    input logic             ovf_o
);
    localparam int unsigned MSB = WIDTH - 1;

    // R1 and R3: addition result with end carry, one cycle later (R8).
    assert_add_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sub_i)) |->
        ({carry_o, sum_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)})));

    // R2 and R4: subtraction as A + ~B + 1 with end carry.
    assert_sub_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sub_i)) |->
        ({carry_o, sum_o} ==
         ({1'b0, $past(a_i)} + {1'b0, ~$past(b_i)} + {{WIDTH{1'b0}}, 1'b1})));

    // R5: signed overflow on addition follows operand and result signs.
    assert_add_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sub_i)) |->
        (ovf_o == (($past(a_i[MSB]) == $past(b_i[MSB])) &&
                   (sum_o[MSB] != $past(a_i[MSB])))));

    // R6: signed overflow on subtraction.
    assert_sub_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sub_i)) |->
        (ovf_o == (($past(a_i[MSB]) != $past(b_i[MSB])) &&
                   (sum_o[MSB] != $past(a_i[MSB])))));

    // R7: outputs cleared while reset is held.
    assert_reset_clear_R7: assert property (@(posedge clk)
        !rst_n |-> (sum_o == '0 && !carry_o && !ovf_o));

endmodule

bind lasub_addsub lasub_checker #(.WIDTH(WIDTH)) u_lasub_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_i     (a_i),
    .b_i     (b_i),
    .sub_i   (sub_i),
    .sum_o   (sum_o),
    .carry_o (carry_o),
    .ovf_o   (ovf_o)
);

// File: tb/lasub_addsub_bench.sv
`timescale 1ns/1ps
module lasub_addsub_bench;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         sub_i = 1'b0;
    logic [W-1:0] sum_o;
    logic         carry_o;
    logic         ovf_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk; // 125 MHz

    lasub_addsub #(.WIDTH(W)) u_lasub_addsub (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_i     (a_i),
        .b_i     (b_i),
        .sub_i   (sub_i),
        .sum_o   (sum_o),
        .carry_o (carry_o),
        .ovf_o   (ovf_o)
    );

    function automatic int sval(input int u);
        return (u >= 8) ? u - 16 : u;
    endfunction

    function automatic int ref_sum(input int a, input int b, input bit s);
        return s ? ((a - b + 16) % 16) : ((a + b) % 16);
    endfunction

    function automatic bit ref_carry(input int a, input int b, input bit s);
        return s ? (a >= b) : ((a + b) >= 16);
    endfunction

    function automatic bit ref_ovf(input int a, input int b, input bit s);
        int r;
        r = s ? (sval(a) - sval(b)) : (sval(a) + sval(b));
        return (r > 7) || (r < -8);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge capture, check at the
    // following falling edge (R8).
    task automatic apply(input int a, input int b, input bit s);
        a_i   = W'(a);
        b_i   = W'(b);
        sub_i = s;
        @(negedge clk);
        if (!s) begin
            check("R1/R8 sum add", int'(sum_o), ref_sum(a, b, s));
            check("R3 carry add", int'(carry_o), int'(ref_carry(a, b, s)));
            check("R5 ovf add", int'(ovf_o), int'(ref_ovf(a, b, s)));
        end else begin
            check("R2/R8 sum sub", int'(sum_o), ref_sum(a, b, s));
            check("R4 carry sub", int'(carry_o), int'(ref_carry(a, b, s)));
            check("R6 ovf sub", int'(ovf_o), int'(ref_ovf(a, b, s)));
        end
    endtask

    initial begin
        void'($urandom(32'd1337));
        // R7: operands that would set every output, held in reset.
        a_i = 4'hF; b_i = 4'hF; sub_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 reset sum", int'(sum_o), 0);
        check("R7 reset carry", int'(carry_o), 0);
        check("R7 reset ovf", int'(ovf_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners.
        apply(7, 1, 1'b0);   // R5 positive overflow
        apply(8, 8, 1'b0);   // R3 carry and R5 negative overflow
        apply(0, 1, 1'b1);   // R4 borrow
        apply(8, 1, 1'b1);   // R6 overflow on subtract
        apply(5, 5, 1'b1);   // R4 equal operands, no borrow
        apply(15, 1, 1'b0);  // R3 wrap to zero

        // Exhaustive sweep of both modes.
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    apply(a, b, s[0]);

        // Seeded random vectors.
        for (int n = 0; n < 200; n++)
            apply(int'($urandom % 16), int'($urandom % 16), 1'($urandom));

        // R7: reset reapplied mid-run clears outputs.
        a_i = 4'h9; b_i = 4'h9; sub_i = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 reassert sum", int'(sum_o), 0);
        check("R7 reassert carry", int'(carry_o), 0);
        check("R7 reassert ovf", int'(ovf_o), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule